// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Optional Ninth Data Bit

This block turns bytes written by a processor into asynchronous serial frames on a single output line. A write to the holding register queues one character. When the transmitter is free, that character moves into a shift register and the holding register is free to take the next one. Software can therefore keep the line busy with no gap between frames by writing again whenever the holding-register-empty flag is raised. The flag can also raise an interrupt request.

Each frame has one low start bit, then the data bits with the least significant bit first, then one high stop bit. The line is high when idle. Each bit lasts 16 × (divisor + 1) clock cycles, where the divisor is an 8-bit register. In nine-bit mode a ninth data bit follows the eight data bits. Its value comes from a control bit and is captured when the character moves into the shift register. Clearing the transmit enable does not cut a frame short. The character being shifted and any character already queued are both sent before the transmitter goes quiet.

Register write map (`wr_addr`): 0 writes the holding register. 1 writes control, with bit 0 the ninth-bit value, bit 1 nine-bit mode, bit 2 transmit enable and bit 3 the holding-empty interrupt enable. 2 writes the divisor. Writes to address 3 are ignored. All registers reset to zero.

The controller has four states:
- IDLE: the line is high. It moves to START when enabled with a character queued.
- START: the start bit. It moves to DATA on a bit tick.
- DATA: the data bits are shifted out. It moves to STOP after the last data bit.
- STOP: the stop bit. At its final tick it moves to START if a character is queued, or to IDLE if not.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1, `tx_done` is 0 and `irq` is 0.
- R2: An 8-bit frame drives `txd` low for the start bit, then data bits 0 to 7 in that order, then high for the stop bit.
- R3: Every bit of a frame lasts exactly 16 × (D + 1) clock cycles, where D is the divisor written at address 2. The start bit begins on the clock edge after the character is transferred, and this holds for the whole range D = 0 to 255.
- R4: With control bit 1 set, a frame carries nine data bits. The ninth bit, sent after data bit 7, equals control bit 0.
- R5: The ninth-bit value and the mode are captured at transfer. Rewriting control bit 0 during a frame does not change that frame.
- R6: A write to address 0 clears `hold_empty` on the following edge. The transfer into the shift register sets `hold_empty` on the edge where the start bit begins. When a write and a transfer fall on the same edge, the flag stays 0.
- R7: A character written while another is being sent starts its start bit on the clock edge right after the previous stop bit ends, with no idle cycles between the frames.
- R8: `tx_done` rises on the edge where a stop bit ends with nothing queued. It is 0 during the frame and clears on a write to address 0.
- R9: Clearing the transmit enable during a frame still lets the current character and a queued character go out in full, after which the line stays idle.
- R10: `irq` is 1 exactly when `hold_empty`, control bit 3 and `glob_irq_en` are all 1.
- R11: A character written while the transmitter is disabled and idle produces no activity on `txd`. It is sent once the enable is set, with the start bit beginning on the edge after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| glob_irq_en | input | 1 | Global interrupt enable |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Last frame finished, nothing pending |
| irq | output | 1 | Holding-empty interrupt request |

## Verification
The bench counts clock edges and tags each register write with the edge on which it takes effect. From that edge it derives when each result is due. `hold_empty` and `tx_done` change on the edge after the write. The transfer happens one edge later, and the start bit begins there. Bit k of a frame then begins 16 × (D + 1) × k edges after that, so each bit's value is checked on its first cycle and at its midpoint. `tx_done` is checked on the cycle before and the cycle of the expected stop-bit end. All sampling is done on falling edges, so every check falls inside the expected cycle window and does not sit on a transition.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_HOLD = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] A_DIV  = 2'd2;

    localparam int C_BIT9 = 0;
    localparam int C_NINE = 1;
    localparam int C_EN   = 2;
    localparam int C_IE   = 3;

endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_i,
    output logic [DATA_W-1:0] hold_o,
    output logic              hold_empty_o,
    output logic              data_wr_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              bit9_o,
    output logic              nine_o,
    output logic              en_o,
    output logic              ie_o
);

    logic ctrl_wr;
    logic div_wr;

    assign data_wr_o = wr_en && (wr_addr == A_HOLD);
    assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
    assign div_wr    = wr_en && (wr_addr == A_DIV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o       <= '0;
            hold_empty_o <= 1'b1;
            div_o        <= '0;
            bit9_o       <= 1'b0;
            nine_o       <= 1'b0;
            en_o         <= 1'b0;
            ie_o         <= 1'b0;
        end else begin
            if (data_wr_o) begin
                hold_o       <= wr_data;
                hold_empty_o <= 1'b0;
            end else if (load_i) begin
                hold_empty_o <= 1'b1;
            end
            if (ctrl_wr) begin
                bit9_o <= wr_data[C_BIT9];
                nine_o <= wr_data[C_NINE];
                en_o   <= wr_data[C_EN];
                ie_o   <= wr_data[C_IE];
            end
            if (div_wr) begin
                div_o <= wr_data[DIV_W-1:0];
            end
        end
    end

    // R6: a data write always leaves the holding register occupied
    p_wr_clears_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_o |=> !hold_empty_o);

    // R6: a transfer with no competing write frees the holding register
    p_load_sets_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !data_wr_o) |=> hold_empty_o);

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W      = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             bit_tick_o
);

    localparam int SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

    logic [DIV_W-1:0] pre_q;
    logic [SUB_W-1:0] sub_q;
    logic             pre_wrap;

    assign pre_wrap   = (pre_q == div_i);
    assign bit_tick_o = pre_wrap && (sub_q == SUB_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (restart_i) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (pre_wrap) begin
            pre_q <= '0;
            sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R3: bit ticks are never adjacent
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |=> !bit_tick_o);

    // R3: a restart begins a full bit period
    p_restart_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !bit_tick_o);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] din_i,
    output logic         lsb_o
);

    logic [W-1:0] sh_q;

    assign lsb_o = sh_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else if (load_i) begin
            sh_q <= din_i;
        end else if (shift_i) begin
            sh_q <= {1'b1, sh_q[W-1:1]};
        end
    end

    // R5: the word presented at transfer is what the shifter holds next
    p_load_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sh_q == $past(din_i)));

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic nine_i,
    input  logic hold_empty_i,
    input  logic data_wr_i,
    input  logic bit_tick_i,
    input  logic lsb_i,
    output logic load_o,
    output logic shift_o,
    output logic txd_o,
    output logic tx_done_o
);

    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LAST_STD = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_EXT = CNT_W'(DATA_W);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             nine_q;
    logic             last_bit;
    logic             queued;

    assign last_bit = (cnt_q == (nine_q ? LAST_EXT : LAST_STD));
    assign queued   = !hold_empty_i;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i && queued) state_d = ST_START;
            end
            ST_START: begin
                if (bit_tick_i) begin
                    state_d = ST_DATA;
                    cnt_d   = '0;
                end
            end
            ST_DATA: begin
                if (bit_tick_i) begin
                    if (last_bit) state_d = ST_STOP;
                    else          cnt_d   = cnt_q + 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_tick_i) state_d = queued ? ST_START : ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            nine_q    <= 1'b0;
            tx_done_o <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load_o) nine_q <= nine_i;
            if (data_wr_i)
                tx_done_o <= 1'b0;
            else if (state_q == ST_STOP && bit_tick_i && !queued)
                tx_done_o <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_o  = 1'b0;
        shift_o = 1'b0;
        txd_o   = 1'b1;
        unique case (state_q)
            ST_IDLE:  load_o = en_i && queued;
            ST_START: txd_o  = 1'b0;
            ST_DATA: begin
                txd_o   = lsb_i;
                shift_o = bit_tick_i;
            end
            ST_STOP:  load_o = bit_tick_i && queued;
        endcase
    end

    // R8: completion is only ever reported while idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |-> (state_q == ST_IDLE));

    // R9: with the enable off, an idle transmitter stays idle
    p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !en_i) |=> (state_q == ST_IDLE));

    // R7: every transfer is followed by a start bit
    p_load_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (state_q == ST_START));

    // R2: data phase begins at bit index zero
    p_data_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && bit_tick_i) |=> (state_q == ST_DATA && cnt_q == '0));

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              glob_irq_en,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_done,
    output logic              irq
);

    localparam int SH_W = DATA_W + 1;

    logic [DATA_W-1:0] hold;
    logic [DIV_W-1:0]  div;
    logic              data_wr;
    logic              bit9, nine, en, ie;
    logic              load, shift, bit_tick, lsb;

    uart_tx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .load_i       (load),
        .hold_o       (hold),
        .hold_empty_o (hold_empty),
        .data_wr_o    (data_wr),
        .div_o        (div),
        .bit9_o       (bit9),
        .nine_o       (nine),
        .en_o         (en),
        .ie_o         (ie)
    );

    uart_tx_baud #(.DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE)) u_baud (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_i      (div),
        .restart_i  (load),
        .bit_tick_o (bit_tick)
    );

    uart_tx_shift #(.W(SH_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .din_i   ({bit9, hold}),
        .lsb_o   (lsb)
    );

    uart_tx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .nine_i       (nine),
        .hold_empty_i (hold_empty),
        .data_wr_i    (data_wr),
        .bit_tick_i   (bit_tick),
        .lsb_i        (lsb),
        .load_o       (load),
        .shift_o      (shift),
        .txd_o        (txd),
        .tx_done_o    (tx_done)
    );

    assign irq = hold_empty && ie && glob_irq_en;

endmodule

// File: tb/uart_tx_dbuf_tb.sv
module uart_tx_dbuf_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       glob_irq_en = 1'b0;
    wire        txd, hold_empty, tx_done, irq;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tx_dbuf u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .glob_irq_en(glob_irq_en), .txd(txd),
        .hold_empty(hold_empty), .tx_done(tx_done), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // drives one write; returns on the falling edge after the capturing edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctrl(input logic en, input logic nine,
                                        input logic b8, input logic ie);
        return {4'b0, ie, en, nine, b8};
    endfunction

    function automatic logic [7:0] pattern(input int k);
        case (k)
            8:       return 8'h00;
            9:       return 8'hFF;
            default: return (8'h01 << k) ^ ((k % 2) ? 8'hFF : 8'h00);
        endcase
    endfunction

    // checks every bit at its first cycle and at its midpoint
    task automatic check_frame(input int base, input int n, input logic [8:0] d,
                               input int nb, input string req);
        for (int j = 0; j <= nb + 1; j++) begin
            logic e;
            e = (j == 0) ? 1'b0 : ((j <= nb) ? d[j-1] : 1'b1);
            wait_until(base + n*j);
            chk(req, txd, e);
            wait_until(base + n*j + n/2);
            chk(req, txd, e);
        end
    endtask

    task automatic send_one(input int dv, input logic [7:0] d, input logic nine,
                            input logic b8, input string req);
        int n, nb, base, fin;
        n  = 16 * (dv + 1);
        nb = nine ? 9 : 8;
        wr(2'd2, 8'(dv));
        wr(2'd1, ctrl(1'b1, nine, b8, 1'b0));
        chk(req, txd, 1'b1);
        wr(2'd0, d);
        chk("R6", hold_empty, 1'b0);
        base = cyc + 1;
        wait_until(base);
        chk("R6", hold_empty, 1'b1);
        check_frame(base, n, {b8, d}, nb, req);
        fin = base + n*(nb + 2);
        wait_until(fin - 1);
        chk("R8", tx_done, 1'b0);
        wait_until(fin);
        chk("R8", tx_done, 1'b1);
        chk(req, txd, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int w, base, n, fin;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", txd, 1'b1);
        chk("R1", hold_empty, 1'b1);
        chk("R1", tx_done, 1'b0);
        chk("R1", irq, 1'b0);

        // R10 exhaustive over empty flag, enable bit and global enable
        for (int he = 1; he >= 0; he--) begin
            if (he == 0) wr(2'd0, 8'h96);
            for (int c = 0; c < 4; c++) begin
                wr(2'd1, ctrl(1'b0, 1'b0, 1'b0, c[0]));
                glob_irq_en = c[1];
                @(negedge clk);
                chk("R10", irq, logic'(he == 1 && c == 3));
            end
        end
        glob_irq_en = 1'b0;
        // R11: queued character while disabled stays silent
        chk("R11", hold_empty, 1'b0);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk("R11", txd, 1'b1);
        end
        wr(2'd1, ctrl(1'b1, 1'b0, 1'b0, 1'b0));
        base = cyc + 1;
        check_frame(base, 16, {1'b0, 8'h96}, 8, "R11");
        wait_until(base + 160);
        chk("R8", tx_done, 1'b1);

        // R2/R3 sweep: divisors 0..3, ten data patterns each
        for (int dv = 0; dv < 4; dv++)
            for (int k = 0; k < 10; k++)
                send_one(dv, pattern(k), 1'b0, 1'b0, "R2");

        // R4 nine-bit frames with both ninth-bit values
        for (int dv = 0; dv < 2; dv++)
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < 4; k++)
                    send_one(dv, pattern(k * 3), 1'b1, b[0], "R4");

        // R3 largest divisor
        send_one(255, 8'hA5, 1'b0, 1'b0, "R3");

        // R5: ninth bit rewritten mid-frame
        wr(2'd2, 8'd0);
        wr(2'd1, ctrl(1'b1, 1'b1, 1'b1, 1'b0));
        wr(2'd0, 8'h3C);
        base = cyc + 1;
        fork
            check_frame(base, 16, 9'h13C, 9, "R5");
            begin
                wait_until(base + 2);
                wr(2'd1, ctrl(1'b1, 1'b0, 1'b0, 1'b0));
            end
        join
        wait_until(base + 16*11);
        chk("R8", tx_done, 1'b1);

        // R7 back-to-back, R9 enable cleared mid-frame
        n = 32;
        wr(2'd2, 8'd1);
        wr(2'd1, ctrl(1'b1, 1'b0, 1'b0, 1'b0));
        wr(2'd0, 8'h5A);
        w = cyc;
        base = w + 1;
        wr(2'd0, 8'hC3);
        chk("R6", hold_empty, 1'b0);
        fork
            begin
                check_frame(base, n, 9'h05A, 8, "R7");
                check_frame(base + n*10, n, 9'h0C3, 8, "R7");
            end
            begin
                wait_until(base + n*3);
                wr(2'd1, ctrl(1'b0, 1'b0, 1'b0, 1'b0));
                wait_until(base + n*10 - 1);
                chk("R6", hold_empty, 1'b0);
                chk("R9", tx_done, 1'b0);
                wait_until(base + n*10);
                chk("R6", hold_empty, 1'b1);
            end
        join
        fin = base + n*20;
        wait_until(fin);
        chk("R9", tx_done, 1'b1);
        chk("R9", txd, 1'b1);

        // R11 again after draining; R8 write clears done
        wr(2'd0, 8'h77);
        chk("R8", tx_done, 1'b0);
        for (int k = 0; k < 3*n; k++) begin
            @(negedge clk);
            chk("R9", txd, 1'b1);
        end
        wr(2'd1, ctrl(1'b1, 1'b0, 1'b0, 1'b0));
        base = cyc + 1;
        check_frame(base, n, 9'h077, 8, "R11");
        wait_until(base + n*10);
        chk("R8", tx_done, 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule